// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Enable Latching

This block controls program and erase operations on a small flash array that is split into small blocks. Software writes one control word. The word holds a block-select mask, a program/erase mode bit, a setup-enable bit and a high-voltage-enable bit. When both enable bits are set and at least one selected block is permitted, the block runs a short embedded sequence.

An erase runs a preprogram phase and then an erase phase. A program runs a single program phase. Each phase lasts `PHASE_CYC` clock cycles. At the end of each phase, a stub input from the array model supplies that phase's pass or fail result.

The block reports three things: a busy flag, a result flag that is meaningful once busy has dropped, and a qualifier that tells which erase phase failed. Two external enable pins gate the operation. The global pin permits high voltage on every block above block 0. A separate pin alone decides whether block 0 may be operated on. Both pins are captured when high voltage is switched on and are held while it stays on.

Top module: `fpe_ctrl`

## Requirements
- R1: The control word is {hv_en at bit NBLK+2, setup at bit NBLK+1, mode at bit NBLK (1 = erase, 0 = program), select at bits NBLK-1:0}. When a write occurs while the stored setup bit is 0, it loads the select mask and the mode. A 1 in select bit M picks small block M.
- R2: A write that occurs while the stored setup bit is 1 leaves the select mask and the mode unchanged. This holds even for the write that clears setup.
- R3: While hv_en is 0, the pin status outputs follow the pins one cycle late. From the edge that sets hv_en until hv_en is cleared, they hold the pin values sampled at that edge.
- R4: Block 0 is permitted only when the latched block-0 status is 1, whatever the global pin says. Blocks 1 and up are permitted only when the latched global status is 1.
- R5: When hv_en and setup are both set and a permitted block is selected, busy rises one cycle after the hv_en write edge. Busy then stays high for PHASE_CYC cycles for a program and for 2*PHASE_CYC cycles for an erase that passes.
- R6: Each phase samples its stub result (pre_ok for preprogram, main_ok for the program or erase phase) on its last cycle. A failure ends the sequence with no further phase.
- R7: The result flag is 1 after a phase run that passed. It is also 1 when no selected block is permitted, and in that case busy never rises. The result flag is 0 while busy is high.
- R8: The result flag and the qualifier are cleared by a write that sets hv_en from 0, and by a write that clears setup. Otherwise they hold their value after busy drops, including across the clearing of hv_en.
- R9: The qualifier reads 0 after a preprogram failure, 1 after an erase-phase failure, and 0 after a program failure.
- R10: Clearing hv_en (or setup) while busy aborts the sequence. Busy falls within one cycle of the stored bit clearing, and the result flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | NBLK+3 | Control word {hv_en, setup, mode, select} |
| pin_gen_en | input | 1 | External global high-voltage permit pin |
| pin_b0_en | input | 1 | External block-0 high-voltage permit pin |
| pre_ok | input | 1 | Stub result of the preprogram phase |
| main_ok | input | 1 | Stub result of the program or erase phase |
| sel_o | output | NBLK | Stored block-select mask |
| mode_o | output | 1 | Stored mode (1 = erase) |
| hvs_o | output | 1 | Busy: sequence in progress |
| good_o | output | 1 | Operation result flag |
| fail_ph_o | output | 1 | Failure-phase qualifier |
| gen_stat_o | output | 1 | Global pin status (latched while hv_en) |
| b0_stat_o | output | 1 | Block-0 pin status (latched while hv_en) |

## Verification
A sequencer stuck in a phase, or one that skips the preprogram phase, shows up at the ports as a busy interval of the wrong length. That is visible on the cycle busy drops, at most 2*PHASE_CYC cycles after the start. A wrong failure record gives the wrong result flag or qualifier as soon as busy falls. A wrong latch or permit mask shows up as a run that should have been skipped, or a skip that should have run, one cycle after the hv_en write. A select register that is not protected is visible on sel_o right after the offending write.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_MAIN = 2'd2,
    ST_DONE = 2'd3
  } seq_st_e;
endpackage

// File: rtl/fpe_rst_sync.sv
module fpe_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/fpe_regs.sv
module fpe_regs #(
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NBLK+2:0] wr_data,
  input  logic            pin_gen,
  input  logic            pin_b0,
  output logic [NBLK-1:0] sel_q,
  output logic            mode_q,
  output logic            ses_q,
  output logic            ehv_q,
  output logic            gen_lat,
  output logic            b0_lat,
  output logic            res_clr
);
  localparam int MODE_B = NBLK;
  localparam int SES_B  = NBLK + 1;
  localparam int EHV_B  = NBLK + 2;

  logic            sel_ld;
  logic            ctl_ld;
  logic            pin_ld;
  logic [NBLK-1:0] sel_d;
  logic            mode_d, ses_d, ehv_d;

  // next-state
  always_comb begin
    sel_ld  = wr_en && !ses_q;
    ctl_ld  = wr_en;
    pin_ld  = !ehv_q;
    sel_d   = wr_data[NBLK-1:0];
    mode_d  = wr_data[MODE_B];
    ses_d   = wr_data[SES_B];
    ehv_d   = wr_data[EHV_B];
    res_clr = wr_en && ((wr_data[EHV_B] && !ehv_q) || !wr_data[SES_B]);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= 1'b0;
    end else if (sel_ld) begin
      sel_q  <= sel_d;
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ses_q <= 1'b0;
      ehv_q <= 1'b0;
    end else if (ctl_ld) begin
      ses_q <= ses_d;
      ehv_q <= ehv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_lat <= 1'b0;
      b0_lat  <= 1'b0;
    end else if (pin_ld) begin
      gen_lat <= pin_gen;
      b0_lat  <= pin_b0;
    end
  end

  p_sel_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ses_q) |=> ($stable(sel_q) && $stable(mode_q)));

  p_pin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ehv_q |=> (!ehv_q || ($stable(gen_lat) && $stable(b0_lat))));
endmodule

// File: rtl/fpe_mask.sv
module fpe_mask #(
  parameter int NBLK = 8
) (
  input  logic [NBLK-1:0] sel,
  input  logic            gen_lat,
  input  logic            b0_lat,
  output logic [NBLK-1:0] en_mask,
  output logic            any_en
);
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    if (i == 0) begin : g_low
      assign en_mask[i] = sel[i] & b0_lat;
    end else begin : g_rest
      assign en_mask[i] = sel[i] & gen_lat;
    end
  end

  assign any_en = |en_mask;
endmodule

// File: rtl/fpe_seq.sv
module fpe_seq #(
  parameter int PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic mode_erase,
  input  logic any_en,
  input  logic pre_ok,
  input  logic main_ok,
  input  logic res_clr,
  output logic busy,
  output logic good,
  output logic pefi
);
  import fpe_pkg::*;

  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          good_d, pefi_d;
  logic          last;

  assign last = (cnt_q == LAST);

  // next-state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    good_d = good;
    pefi_d = pefi;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          cnt_d = '0;
          if (any_en) begin
            st_d = mode_erase ? ST_PRE : ST_MAIN;
          end else begin
            st_d   = ST_DONE;
            good_d = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (!go) begin
          st_d = ST_IDLE;
        end else if (last) begin
          cnt_d = '0;
          if (pre_ok) begin
            st_d = ST_MAIN;
          end else begin
            st_d   = ST_DONE;
            good_d = 1'b0;
            pefi_d = 1'b0;
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_MAIN: begin
        if (!go) begin
          st_d = ST_IDLE;
        end else if (last) begin
          st_d   = ST_DONE;
          good_d = main_ok;
          pefi_d = !main_ok && mode_erase;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_DONE: begin
        if (!go) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (res_clr) begin
      good_d = 1'b0;
      pefi_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      good  <= 1'b0;
      pefi  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      good  <= good_d;
      pefi  <= pefi_d;
    end
  end

  assign busy = (st_q == ST_PRE) || (st_q == ST_MAIN);

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go && any_en));

  p_good_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !good);

  p_res_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_clr |=> (!good && !pefi));

  p_pefi_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pefi |-> (!good && mode_erase));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go) |=> !busy);
endmodule

// File: rtl/fpe_ctrl.sv
module fpe_ctrl #(
  parameter int NBLK      = 8,
  parameter int PHASE_CYC = 4
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            wr_en,
  input  logic [NBLK+2:0] wr_data,
  input  logic            pin_gen_en,
  input  logic            pin_b0_en,
  input  logic            pre_ok,
  input  logic            main_ok,
  output logic [NBLK-1:0] sel_o,
  output logic            mode_o,
  output logic            hvs_o,
  output logic            good_o,
  output logic            fail_ph_o,
  output logic            gen_stat_o,
  output logic            b0_stat_o
);
  logic            rst_n;
  logic            ses_q, ehv_q, res_clr;
  logic            gen_lat, b0_lat;
  logic [NBLK-1:0] en_mask;
  logic            any_en;

  fpe_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  fpe_regs #(.NBLK(NBLK)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .pin_gen (pin_gen_en),
    .pin_b0  (pin_b0_en),
    .sel_q   (sel_o),
    .mode_q  (mode_o),
    .ses_q   (ses_q),
    .ehv_q   (ehv_q),
    .gen_lat (gen_lat),
    .b0_lat  (b0_lat),
    .res_clr (res_clr)
  );

  fpe_mask #(.NBLK(NBLK)) u_mask (
    .sel     (sel_o),
    .gen_lat (gen_lat),
    .b0_lat  (b0_lat),
    .en_mask (en_mask),
    .any_en  (any_en)
  );

  fpe_seq #(.PHASE_CYC(PHASE_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (ehv_q && ses_q),
    .mode_erase (mode_o),
    .any_en     (any_en),
    .pre_ok     (pre_ok),
    .main_ok    (main_ok),
    .res_clr    (res_clr),
    .busy       (hvs_o),
    .good       (good_o),
    .pefi       (fail_ph_o)
  );

  assign gen_stat_o = gen_lat;
  assign b0_stat_o  = b0_lat;

  p_b0_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hvs_o) && sel_o == NBLK'(1)) |-> b0_lat);

  p_gen_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hvs_o) && !sel_o[0]) |-> gen_lat);

  p_mask_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask & ~sel_o) == '0);
endmodule

// File: tb/fpe_ctrl_tb_top.sv
module fpe_ctrl_tb_top;
  localparam int NBLK = 8;
  localparam int P    = 4;
  localparam int W    = NBLK + 3;

  logic            clk = 1'b0;
  logic            arst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [W-1:0]    wr_data = '0;
  logic            pin_gen_en = 1'b0;
  logic            pin_b0_en = 1'b0;
  logic            pre_ok = 1'b1;
  logic            main_ok = 1'b1;
  logic [NBLK-1:0] sel_o;
  logic            mode_o, hvs_o, good_o, fail_ph_o, gen_stat_o, b0_stat_o;

  fpe_ctrl #(.NBLK(NBLK), .PHASE_CYC(P)) dut_i (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pin_gen_en(pin_gen_en), .pin_b0_en(pin_b0_en),
    .pre_ok(pre_ok), .main_ok(main_ok),
    .sel_o(sel_o), .mode_o(mode_o), .hvs_o(hvs_o), .good_o(good_o),
    .fail_ph_o(fail_ph_o), .gen_stat_o(gen_stat_o), .b0_stat_o(b0_stat_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic  good;
    logic  pefi;
    int    dur;
    string req;
  } exp_t;

  exp_t q[$];
  event arm_ev, chk_ev;
  int   n_chk = 0;
  int   n_fail = 0;
  int   busy_total = 0;
  bit   finished = 0;

  always @(posedge clk) if (hvs_o) busy_total <= busy_total + 1;

  task automatic chk(string req, int act, int exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pops expected results and compares at the ports
  initial begin
    int base;
    exp_t e;
    forever begin
      @(arm_ev);
      base = busy_total;
      @(chk_ev);
      e = q.pop_front();
      chk({e.req, " busy cycles"}, busy_total - base, e.dur);
      chk({e.req, " result"}, int'(good_o), int'(e.good));
      chk({e.req, " qualifier"}, int'(fail_ph_o), int'(e.pefi));
    end
  end

  task automatic wr(logic [NBLK-1:0] sel, logic mode, logic ses, logic ehv);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = {ehv, ses, mode, sel};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // driver: full operation, expected item pushed to the scoreboard
  task automatic run_op(string req, logic [NBLK-1:0] sel, logic mode,
                        logic g, logic b0, logic pok, logic mok,
                        logic eg, logic ep, int dur);
    exp_t e;
    pin_gen_en = g; pin_b0_en = b0; pre_ok = pok; main_ok = mok;
    wr(sel, mode, 1'b0, 1'b0);
    wr(sel, mode, 1'b1, 1'b0);
    e.good = eg; e.pefi = ep; e.dur = dur; e.req = req;
    q.push_back(e);
    -> arm_ev;
    wr(sel, mode, 1'b1, 1'b1);
    chk({req, " R5 busy low at write"}, int'(hvs_o), 0);
    @(negedge clk);
    chk({req, " R5 busy one cycle later"}, int'(hvs_o), (dur > 0) ? 1 : 0);
    repeat (2 * P + 3) @(negedge clk);
    -> chk_ev;
    @(negedge clk);
    wr(sel, mode, 1'b1, 1'b0);
    chk({req, " R8 result held after hv off"}, int'(good_o), int'(eg));
    wr(sel, mode, 1'b0, 1'b0);
    chk({req, " R8 result cleared by setup clear"}, int'(good_o), 0);
    chk({req, " R8 qualifier cleared"}, int'(fail_ph_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R7 reset busy", int'(hvs_o), 0);
    chk("R7 reset result", int'(good_o), 0);
    chk("R9 reset qualifier", int'(fail_ph_o), 0);
    chk("R1 reset select", int'(sel_o), 0);

    // R1 / R2 select and mode protection
    wr(8'hA5, 1'b1, 1'b0, 1'b0);
    chk("R1 select loaded", int'(sel_o), 'hA5);
    chk("R1 mode loaded", int'(mode_o), 1);
    wr(8'hA5, 1'b1, 1'b1, 1'b0);
    wr(8'h5A, 1'b0, 1'b1, 1'b0);
    chk("R2 select locked", int'(sel_o), 'hA5);
    chk("R2 mode locked", int'(mode_o), 1);
    wr(8'h5A, 1'b0, 1'b0, 1'b0);
    chk("R2 clearing write still locked", int'(sel_o), 'hA5);
    wr(8'h5A, 1'b0, 1'b0, 1'b0);
    chk("R1 select after unlock", int'(sel_o), 'h5A);

    // sequencing and results
    run_op("R5 program pass",        8'h0E, 1'b0, 1, 0, 0, 1, 1, 0, P);
    run_op("R5 erase pass",          8'h0E, 1'b1, 1, 0, 1, 1, 1, 0, 2 * P);
    run_op("R9 erase preprog fail",  8'h0E, 1'b1, 1, 0, 0, 1, 0, 0, P);
    run_op("R9 erase main fail",     8'h0E, 1'b1, 1, 0, 1, 0, 0, 1, 2 * P);
    run_op("R6 program fail",        8'h0E, 1'b0, 1, 0, 0, 0, 0, 0, P);
    run_op("R7 protected upper",     8'h02, 1'b0, 0, 1, 1, 1, 1, 0, 0);
    run_op("R4 block0 by own pin",   8'h01, 1'b0, 0, 1, 1, 1, 1, 0, P);
    run_op("R4 block0 blocked",      8'h01, 1'b1, 1, 0, 1, 1, 1, 0, 0);
    run_op("R4 all selected gen on", 8'hFF, 1'b0, 1, 0, 1, 1, 1, 0, P);

    // R8 re-assert of hv_en clears the result and reruns
    pin_gen_en = 1; pin_b0_en = 0; pre_ok = 1; main_ok = 1;
    wr(8'h04, 1'b0, 1'b0, 1'b0);
    wr(8'h04, 1'b0, 1'b1, 1'b1);
    repeat (P + 3) @(negedge clk);
    wr(8'h04, 1'b0, 1'b1, 1'b0);
    chk("R8 result held hv off", int'(good_o), 1);
    wr(8'h04, 1'b0, 1'b1, 1'b1);
    chk("R8 result cleared by hv set", int'(good_o), 0);
    repeat (P + 3) @(negedge clk);
    chk("R8 rerun result", int'(good_o), 1);
    wr(8'h04, 1'b0, 1'b0, 1'b0);

    // R3 pin latching, including a pin drop during a run
    pin_gen_en = 1; pin_b0_en = 0;
    wr(8'h02, 1'b0, 1'b0, 1'b0);
    wr(8'h02, 1'b0, 1'b1, 1'b1);
    pin_gen_en = 0; pin_b0_en = 1;
    repeat (3) @(negedge clk);
    chk("R3 global held", int'(gen_stat_o), 1);
    chk("R3 block0 held", int'(b0_stat_o), 0);
    repeat (P) @(negedge clk);
    chk("R3 run unaffected by pin drop", int'(good_o), 1);
    wr(8'h02, 1'b0, 1'b1, 1'b0);
    chk("R3 still old at release edge", int'(gen_stat_o), 1);
    @(negedge clk);
    chk("R3 global follows after release", int'(gen_stat_o), 0);
    chk("R3 block0 follows after release", int'(b0_stat_o), 1);
    wr(8'h02, 1'b0, 1'b0, 1'b0);

    // R10 abort
    pin_gen_en = 1; pin_b0_en = 1; pre_ok = 1; main_ok = 1;
    wr(8'h0F, 1'b1, 1'b0, 1'b0);
    wr(8'h0F, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10 busy before abort", int'(hvs_o), 1);
    wr(8'h0F, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R10 busy cleared", int'(hvs_o), 0);
    chk("R10 result stays 0", int'(good_o), 0);
    repeat (2 * P) @(negedge clk);
    chk("R10 no late result", int'(good_o), 0);
    chk("R10 no late busy", int'(hvs_o), 0);

    summary();
  end
endmodule